// File: doc/BRIEF.md
# Access-Driven DRAM Refresh Controller

This block drives the row and column strobes and the multiplexed address of an asynchronous DRAM for a small processor. No dedicated refresh cycles are generated. Each bus request is marked as a DRAM access or a ROM access. Both kinds open a DRAM row. Only a DRAM access goes on to a column strobe. A ROM fetch therefore leaves behind a row-only strobe, and that strobe refreshes the addressed row. The row address is taken from the least-significant address bits. Straight-line code fetches and ordered data sweeps therefore step through every row in turn.

A coverage monitor checks that the software keeps its part of the bargain. It keeps one bit per row, and that bit is set by any row strobe. The bitmap is cleared at the start of every retention window. The window is timed by a prescaler and a tick counter; for example, 50,000 × 256 cycles at 200 MHz gives 64 ms. When a window closes with any row not strobed, a sticky `refresh_miss` flag goes high and the lowest unstrobed row index is captured. The row count must be a power of two, and in practice equals the square root of the device's bit count.

The strobe sequencer has five states:
- `ST_IDLE` moves to `ST_ROW` when a request is accepted.
- `ST_ROW` moves to `ST_COL` for a DRAM access, or to `ST_DONE` for a ROM access, once T_RCD cycles have passed.
- `ST_COL` moves to `ST_DONE` after T_CAS cycles.
- `ST_DONE` moves to `ST_PRE`, or straight to `ST_IDLE` when T_PRE is 1.
- `ST_PRE` moves to `ST_IDLE` once the precharge count runs out.

Top module: `dram_sweep_refresh_ctrl`

## Requirements
- R1: Every accepted request drives `dram_ras_n` low. It stays low for exactly T_RCD cycles on a ROM access (`req_rom`=1) and for exactly T_RCD+T_CAS cycles on a DRAM access (`req_rom`=0).
- R2: `dram_cas_n` goes low only on DRAM accesses, and never while `dram_ras_n` is high. It stays low for exactly T_CAS cycles, beginning after T_RCD cycles of row strobe.
- R3: During the row-only phase, `dram_addr` holds `req_addr[ROW_W-1:0]` steady. While `dram_cas_n` is low, it carries `req_addr[ROW_W+COL_W-1:ROW_W]`.
- R4: On a DRAM access, `dram_cas_n` and `dram_ras_n` return high on the same clock edge.
- R5: `req_ready` is a one-cycle pulse. It appears in the first cycle after the strobes return high. `dram_ras_n` then stays high for at least T_PRE cycles before the next access.
- R6: A retention window lasts PRESCALE×WINDOW_TICKS cycles, counted from reset release. `refresh_miss` can change only on the edge that closes a window.
- R7: A ROM (row-only) access marks its row as refreshed in the same way as a DRAM access.
- R8: A window in which every row was strobed leaves `refresh_miss` and `miss_row` unchanged.
- R9: A window that closes with some row unstrobed sets `refresh_miss`. The flag then stays high until reset, and `miss_row` is loaded with the lowest unstrobed row index. Later fully covered windows change neither.
- R10: Coverage is cleared at every window start. Strobes from an earlier window do not count towards the next one.
- R11: During reset, both strobes are high, `req_ready` is low, `refresh_miss` is 0 and `miss_row` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request; held until `req_ready` |
| req_addr | input | ROW_W+COL_W | Request address; the low bits select the row |
| req_rom | input | 1 | 1 = ROM access (row strobe only), 0 = DRAM access |
| req_ready | output | 1 | One-cycle completion pulse |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| refresh_miss | output | 1 | Sticky flag: a window closed with a row unstrobed |
| miss_row | output | ROW_W | Lowest unstrobed row of the last failing window |

## Verification
The assertions check on every cycle the shape of each strobe:
- the column strobe appears only inside a row strobe, and never on a ROM access;
- both strobes release on the same edge;
- the row address stays steady while it is presented;
- the ready pulse is single and follows the strobes;
- the precharge gap is respected;
- the miss flag is sticky and changes only when a window closes.

The exact strobe lengths, the row and column values, and window coverage need the bench's scenarios. These are: windows covered only by ROM fetches, windows with rows skipped, fully covered windows after a miss, and a reset followed by a window that relies on rows strobed earlier.

// File: rtl/drc_pkg.sv
package drc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_COL,
        ST_DONE,
        ST_PRE
    } drc_state_e;

endpackage

// File: rtl/drc_window_timer.sv
// Retention window timer: prescaler followed by a tick counter.
module drc_window_timer #(
    parameter int PRESCALE     = 50000,
    parameter int WINDOW_TICKS = 256,
    localparam int PW          = $clog2(PRESCALE + 1),
    localparam int TW          = $clog2(WINDOW_TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    output logic window_end
);

    logic [PW-1:0] pre_q;
    logic [TW-1:0] tick_q;
    logic          tick;

    assign tick       = (pre_q == PW'(PRESCALE - 1));
    assign window_end = tick && (tick_q == TW'(WINDOW_TICKS - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q  <= '0;
            tick_q <= '0;
        end else begin
            if (tick) begin
                pre_q <= '0;
                if (window_end) begin
                    tick_q <= '0;
                end else begin
                    tick_q <= tick_q + TW'(1);
                end
            end else begin
                pre_q <= pre_q + PW'(1);
            end
        end
    end

endmodule

// File: rtl/drc_row_tracker.sv
// One coverage bit per row; evaluated and cleared at each window end.
module drc_row_tracker #(
    parameter int ROWS   = 256,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic [ROW_W-1:0] hit_row,
    input  logic             window_end,
    output logic             refresh_miss,
    output logic [ROW_W-1:0] miss_row
);

    logic [ROWS-1:0]  seen_q;
    logic [ROWS-1:0]  seen_now;
    logic             all_seen;
    logic [ROW_W-1:0] first_gap;

    // A strobe in the closing cycle still counts for the closing window.
    always_comb begin
        seen_now = seen_q;
        if (hit) begin
            seen_now[hit_row] = 1'b1;
        end
    end

    assign all_seen = &seen_now;

    // Lowest-index clear bit.
    always_comb begin
        first_gap = '0;
        for (int i = ROWS - 1; i >= 0; i--) begin
            if (!seen_now[i]) begin
                first_gap = ROW_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q       <= '0;
            refresh_miss <= 1'b0;
            miss_row     <= '0;
        end else if (window_end) begin
            seen_q <= '0;
            if (!all_seen) begin
                refresh_miss <= 1'b1;
                miss_row     <= first_gap;
            end
        end else begin
            seen_q <= seen_now;
        end
    end

endmodule

// File: rtl/drc_addr_mux.sv
// Row/column multiplexer onto the shared DRAM address pins.
module drc_addr_mux #(
    parameter int ROW_W  = 8,
    parameter int COL_W  = 8,
    localparam int MUX_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    input  logic             sel_col,
    output logic [MUX_W-1:0] dram_addr
);

    logic [MUX_W-1:0] row_p;
    logic [MUX_W-1:0] col_p;

    if (ROW_W == MUX_W) begin : g_row_full
        assign row_p = row;
    end else begin : g_row_pad
        assign row_p = {{(MUX_W - ROW_W){1'b0}}, row};
    end

    if (COL_W == MUX_W) begin : g_col_full
        assign col_p = col;
    end else begin : g_col_pad
        assign col_p = {{(MUX_W - COL_W){1'b0}}, col};
    end

    assign dram_addr = sel_col ? col_p : row_p;

endmodule

// File: rtl/drc_strobe_fsm.sv
// Strobe sequencer: row phase, optional column phase, ready, precharge.
module drc_strobe_fsm
    import drc_pkg::*;
#(
    parameter int ROW_W   = 8,
    parameter int COL_W   = 8,
    parameter int T_RCD   = 2,
    parameter int T_CAS   = 2,
    parameter int T_PRE   = 2,
    localparam int ADDR_W = ROW_W + COL_W,
    localparam int MAXA   = (T_RCD > T_CAS) ? T_RCD : T_CAS,
    localparam int MAXD   = (MAXA > T_PRE) ? MAXA : T_PRE,
    localparam int CW     = $clog2(MAXD + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_rom,
    output logic              accept,
    output logic [ROW_W-1:0]  row_q,
    output logic [COL_W-1:0]  col_q,
    output logic              rom_q,
    output logic              sel_col,
    output logic              ras_n,
    output logic              cas_n,
    output logic              req_ready
);

    drc_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    assign accept = (state_q == ST_IDLE) && req_valid;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = ST_ROW;
                    cnt_d   = CW'(T_RCD - 1);
                end
            end
            ST_ROW: begin
                if (cnt_q == '0) begin
                    if (rom_q) begin
                        state_d = ST_DONE;
                    end else begin
                        state_d = ST_COL;
                        cnt_d   = CW'(T_CAS - 1);
                    end
                end else begin
                    cnt_d = cnt_q - CW'(1);
                end
            end
            ST_COL: begin
                if (cnt_q == '0) begin
                    state_d = ST_DONE;
                end else begin
                    cnt_d = cnt_q - CW'(1);
                end
            end
            ST_DONE: begin
                if (T_PRE > 1) begin
                    state_d = ST_PRE;
                    cnt_d   = CW'(T_PRE - 2);
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_PRE: begin
                if (cnt_q == '0) begin
                    state_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_q - CW'(1);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            row_q   <= '0;
            col_q   <= '0;
            rom_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (accept) begin
                row_q <= req_addr[ROW_W-1:0];
                col_q <= req_addr[ADDR_W-1:ROW_W];
                rom_q <= req_rom;
            end
        end
    end

    // Outputs decoded from the state
    always_comb begin
        ras_n     = 1'b1;
        cas_n     = 1'b1;
        sel_col   = 1'b0;
        req_ready = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ROW:  ras_n = 1'b0;
            ST_COL: begin
                ras_n   = 1'b0;
                cas_n   = 1'b0;
                sel_col = 1'b1;
            end
            ST_DONE: req_ready = 1'b1;
            ST_PRE:  ;
            default: ;
        endcase
    end

endmodule

// File: rtl/dram_sweep_refresh_ctrl.sv
module dram_sweep_refresh_ctrl #(
    parameter int ROWS         = 256,
    parameter int COLS         = 256,
    parameter int T_RCD        = 2,
    parameter int T_CAS        = 2,
    parameter int T_PRE        = 2,
    parameter int PRESCALE     = 50000,
    parameter int WINDOW_TICKS = 256,
    localparam int ROW_W       = $clog2(ROWS),
    localparam int COL_W       = $clog2(COLS),
    localparam int ADDR_W      = ROW_W + COL_W,
    localparam int MUX_W       = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_rom,
    output logic              req_ready,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic [MUX_W-1:0]  dram_addr,
    output logic              refresh_miss,
    output logic [ROW_W-1:0]  miss_row
);

    logic             accept;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic             cyc_rom;
    logic             sel_col;
    logic             win_end;

    drc_strobe_fsm #(
        .ROW_W (ROW_W),
        .COL_W (COL_W),
        .T_RCD (T_RCD),
        .T_CAS (T_CAS),
        .T_PRE (T_PRE)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_rom   (req_rom),
        .accept    (accept),
        .row_q     (row_q),
        .col_q     (col_q),
        .rom_q     (cyc_rom),
        .sel_col   (sel_col),
        .ras_n     (dram_ras_n),
        .cas_n     (dram_cas_n),
        .req_ready (req_ready)
    );

    drc_addr_mux #(
        .ROW_W (ROW_W),
        .COL_W (COL_W)
    ) u_mux (
        .row       (row_q),
        .col       (col_q),
        .sel_col   (sel_col),
        .dram_addr (dram_addr)
    );

    drc_window_timer #(
        .PRESCALE     (PRESCALE),
        .WINDOW_TICKS (WINDOW_TICKS)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .window_end (win_end)
    );

    drc_row_tracker #(
        .ROWS (ROWS)
    ) u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .hit          (accept),
        .hit_row      (req_addr[ROW_W-1:0]),
        .window_end   (win_end),
        .refresh_miss (refresh_miss),
        .miss_row     (miss_row)
    );

endmodule

// File: rtl/drc_checker.sv
module drc_checker #(
    parameter int MUX_W = 8,
    parameter int T_PRE = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ras_n,
    input logic             cas_n,
    input logic [MUX_W-1:0] dram_addr,
    input logic             req_ready,
    input logic             refresh_miss,
    input logic             cur_rom,
    input logic             window_end
);

    // Count of RAS-high cycles, saturating at T_PRE.
    int hi_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= T_PRE;
        end else if (!ras_n) begin
            hi_cnt <= 0;
        end else if (hi_cnt < T_PRE) begin
            hi_cnt <= hi_cnt + 1;
        end
    end

    p_cas_inside_ras_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);

    p_rom_no_cas_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && cur_rom) |-> cas_n);

    p_cas_release_with_ras_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_n) |-> $rose(ras_n));

    p_row_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && cas_n && $past(!ras_n)) |-> $stable(dram_addr));

    p_ready_after_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (ras_n && $past(!ras_n)));

    p_ready_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);

    p_precharge_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (hi_cnt >= T_PRE));

    p_miss_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_miss |=> refresh_miss);

    p_miss_at_window_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(refresh_miss) |-> $past(window_end));

endmodule

bind dram_sweep_refresh_ctrl drc_checker #(
    .MUX_W (MUX_W),
    .T_PRE (T_PRE)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ras_n        (dram_ras_n),
    .cas_n        (dram_cas_n),
    .dram_addr    (dram_addr),
    .req_ready    (req_ready),
    .refresh_miss (refresh_miss),
    .cur_rom      (cyc_rom),
    .window_end   (win_end)
);

// File: tb/tb_dram_sweep_refresh_ctrl.sv
`timescale 1ns/1ps
module tb_dram_sweep_refresh_ctrl;

    localparam int ROWS = 16, COLS = 16;
    localparam int T_RCD = 2, T_CAS = 2, T_PRE = 2;
    localparam int PRESCALE = 8, WINDOW_TICKS = 32;
    localparam int ROW_W = 4, COL_W = 4, ADDR_W = 8, MUX_W = 4;
    localparam int WIN = PRESCALE * WINDOW_TICKS;

    typedef struct {
        bit rom;
        int row;
        int col;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_rom = 1'b0;
    logic              req_ready;
    logic              dram_ras_n;
    logic              dram_cas_n;
    logic [MUX_W-1:0]  dram_addr;
    logic              refresh_miss;
    logic [ROW_W-1:0]  miss_row;

    dram_sweep_refresh_ctrl #(
        .ROWS (ROWS), .COLS (COLS),
        .T_RCD (T_RCD), .T_CAS (T_CAS), .T_PRE (T_PRE),
        .PRESCALE (PRESCALE), .WINDOW_TICKS (WINDOW_TICKS)
    ) dut (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_addr (req_addr), .req_rom (req_rom),
        .req_ready (req_ready),
        .dram_ras_n (dram_ras_n), .dram_cas_n (dram_cas_n), .dram_addr (dram_addr),
        .refresh_miss (refresh_miss), .miss_row (miss_row)
    );

    always #2.5 clk = ~clk;

    int   checks = 0;
    int   errors = 0;
    int   edge_cnt = 0;
    exp_t exp_q[$];
    bit   seen[ROWS];
    int   exp_miss = 0;
    int   exp_row = 0;

    always @(posedge clk) begin
        if (!rst_n) edge_cnt <= 0;
        else        edge_cnt <= edge_cnt + 1;
    end

    task automatic check(input string tag, input int act, input int expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // Monitor: rebuilds each strobe cycle and compares with the scoreboard.
    int in_cyc = 0, ras_cnt = 0, cas_cnt = 0, cas_start = 0;
    int row_seen = 0, col_seen = 0, last_cas_low = 0, gap = 1000;
    always @(negedge clk) begin
        if (!rst_n) begin
            in_cyc = 0;
            gap    = 1000;
        end else begin
            if (req_ready && !(in_cyc != 0 && dram_ras_n))
                check("R5 ready outside completion", 1, 0);
            if (!dram_ras_n) begin
                if (in_cyc == 0) begin
                    in_cyc = 1;
                    check("R5 precharge gap at least T_PRE", int'(gap >= T_PRE), 1);
                    ras_cnt   = 0;
                    cas_cnt   = 0;
                    cas_start = -1;
                    row_seen  = int'(dram_addr);
                    col_seen  = -1;
                end
                if (!dram_cas_n) begin
                    if (cas_cnt == 0) begin
                        cas_start = ras_cnt;
                        col_seen  = int'(dram_addr);
                    end
                    cas_cnt++;
                end
                ras_cnt++;
                last_cas_low = int'(!dram_cas_n);
            end else begin
                if (!dram_cas_n) check("R2 CAS without RAS", 1, 0);
                if (in_cyc != 0) begin
                    in_cyc = 0;
                    gap    = 1;
                    check("R5 ready in cycle after strobes", int'(req_ready), 1);
                    if (exp_q.size() == 0) begin
                        check("R1 unexpected strobe cycle", 1, 0);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        check("R1 RAS low length", ras_cnt, e.rom ? T_RCD : T_RCD + T_CAS);
                        check("R2 CAS low length", cas_cnt, e.rom ? 0 : T_CAS);
                        check("R3 row address", row_seen, e.row);
                        if (!e.rom) begin
                            check("R2 CAS start after T_RCD", cas_start, T_RCD);
                            check("R3 column address", col_seen, e.col);
                            check("R4 CAS low up to RAS release", last_cas_low, 1);
                        end
                    end
                end else begin
                    gap++;
                end
            end
        end
    end

    task automatic access(input bit rom, input int row, input int col);
        exp_q.push_back('{rom, row, col});
        seen[row] = 1'b1;
        req_rom   = rom;
        req_addr  = {col[COL_W-1:0], row[ROW_W-1:0]};
        req_valid = 1'b1;
        do @(negedge clk); while (!req_ready);
        req_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst_n     = 1'b0;
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        check("R11 reset ras_n", int'(dram_ras_n), 1);
        check("R11 reset cas_n", int'(dram_cas_n), 1);
        check("R11 reset req_ready", int'(req_ready), 0);
        check("R11 reset refresh_miss", int'(refresh_miss), 0);
        check("R11 reset miss_row", int'(miss_row), 0);
        rst_n    = 1'b1;
        exp_miss = 0;
        exp_row  = 0;
        foreach (seen[i]) seen[i] = 1'b0;
    endtask

    // Close a window: flag unchanged one edge early, updated at its end.
    task automatic window_check(input int end_edge, input string tag);
        int lowest;
        lowest = -1;
        for (int i = ROWS - 1; i >= 0; i--)
            if (!seen[i]) lowest = i;
        while (edge_cnt < end_edge - 1) @(negedge clk);
        check("R6 flag unchanged before window end", int'(refresh_miss), exp_miss);
        while (edge_cnt < end_edge) @(negedge clk);
        if (lowest >= 0) begin
            exp_miss = 1;
            exp_row  = lowest;
        end
        check({tag, " refresh_miss"}, int'(refresh_miss), exp_miss);
        check({tag, " miss_row"}, int'(miss_row), exp_row);
        foreach (seen[i]) seen[i] = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // Window 1: rows 0..7 only by ROM fetches (R7), rows 8..15 by DRAM.
        for (int r = 0; r < 8; r++) access(1'b1, r, r + 3);
        for (int r = 8; r < 16; r++) access(1'b0, r, 15 - r);
        window_check(WIN, "R7 R8 covered window");
        // Window 2: rows 5 and 11 skipped (R9).
        for (int r = 0; r < 16; r++)
            if (r != 5 && r != 11) access(r[0], r, (r * 5) % 16);
        window_check(2 * WIN, "R9 missed rows");
        // Window 3: full coverage after a miss keeps flag and row (R9).
        for (int r = 15; r >= 0; r--) access(1'b0, r, r);
        window_check(3 * WIN, "R9 sticky after covered window");
        // Reset clears status; coverage does not carry between windows (R10).
        do_reset();
        for (int r = 0; r < 16; r++) access(1'b1, r, 0);
        window_check(WIN, "R8 second covered window");
        for (int r = 0; r < 3; r++) access(1'b0, r, 9);
        window_check(2 * WIN, "R10 coverage cleared per window");
        repeat (4) @(negedge clk);
        check("R1 all expected cycles observed", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule